// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Self-Locking Enable

The block is a down-counting watchdog timer driven from a plain single-cycle register bus. Software writes a reload value and then turns the timer on. When the counter runs out the first time, an interrupt status is set and the counter starts again from the reload value. If software has not cleared that status by the time the counter runs out a second time, and resets are enabled, the block raises a reset request. The request stays high until the block itself is reset.

The run/interrupt enable bit locks itself. Once software has set it, software cannot clear it again. Only the asynchronous hardware reset or the synchronous software-reset input can release it. Either reset returns every register to its reset value. The interrupt output is either a level that follows the status, or a single-cycle pulse when the status is set. A control bit picks between the two.

Top module: `guard_timer`

## Requirements
- R1: After hardware reset the control register (index 2) reads 0, the load register (index 0) and the count (index 1) read all ones, and `irq` and `rst_req` are 0.
- R2: The count drops by one per clock only while control bit 0 (enable) is 1. Otherwise it holds. It reads at index 1, and bus writes to index 1 are ignored.
- R3: When the count is 0 while enabled, the next cycle sets the interrupt status and reloads the count from the load register. A time-out therefore comes every load+1 cycles after enabling.
- R4: If the status is already set at a time-out and control bit 1 (reset enable) is 1, `rst_req` goes to 1 the next cycle and stays 1 until a reset. With bit 1 at 0, `rst_req` never rises.
- R5: A write of any data to index 3 clears the interrupt status and reloads the count from the load register. If it lands in the same cycle as a time-out, the clear wins.
- R6: With control bit 2 at 0, `irq` is a level equal to the status. With bit 2 at 1, `irq` is high for exactly one cycle when the status goes from 0 to 1.
- R7: Once control bit 0 is 1, bus writes cannot return it to 0. Bits 1 and 2 stay freely writable.
- R8: A high `soft_rst` at a clock edge returns every register and output to its R1 reset value, and this releases the enable lock.
- R9: Control bits 31 to 3 always read 0 and are not stored by writes.
- R10: A write to index 0 stores the load value and puts that value into the count on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset, active high; also unlocks the enable |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Register word index: 0 load, 1 count, 2 control, 3 clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr` (combinational) |
| irq | output | 1 | Interrupt, level or pulse as picked by control bit 2 |
| rst_req | output | 1 | Sticky reset request after an uncleared second time-out |

## Verification
The assertions check the following on every cycle:
- the enable lock;
- that `rst_req` is sticky and rises only when reset enable was set;
- single-cycle decrement while running and a frozen count while stopped;
- that `irq` falls after a clear, and that a pulse-mode `irq` is never high two cycles in a row;
- zero reserved control bits.

Only the bench scenarios can show the exact time-out period for each load value. They also show the cycle on which the reset request appears, that a status cleared in time prevents the reset, and that either reset releases the lock.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] IDX_LOAD  = 2'd0;
    localparam logic [ADDR_W-1:0] IDX_COUNT = 2'd1;
    localparam logic [ADDR_W-1:0] IDX_CTRL  = 2'd2;
    localparam logic [ADDR_W-1:0] IDX_CLEAR = 2'd3;

    localparam int unsigned BIT_EN    = 0;
    localparam int unsigned BIT_RSTEN = 1;
    localparam int unsigned BIT_PULSE = 2;

    typedef struct packed {
        logic pulse;
        logic rst_en;
        logic en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{pulse: 1'b0, rst_en: 1'b0, en: 1'b0};

endpackage

// File: rtl/guard_regs.sv
module guard_regs
    import guard_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  count,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  load_new,
    output logic              load_wr,
    output logic              clear_wr,
    output logic [REG_W-1:0]  bus_rdata
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] load;
    } regs_t;

    localparam regs_t REGS_RST = '{ctrl: CTRL_RST, load: '1};

    regs_t regs_d, regs_q;
    logic  ctrl_wr;

    always_comb begin
        regs_d   = regs_q;
        load_wr  = bus_wr && (bus_addr == IDX_LOAD);
        ctrl_wr  = bus_wr && (bus_addr == IDX_CTRL);
        clear_wr = bus_wr && (bus_addr == IDX_CLEAR);
        if (load_wr) begin
            regs_d.load = bus_wdata[CNT_W-1:0];
        end
        if (ctrl_wr) begin
            // enable is set-only: it can be raised by a write but never dropped
            regs_d.ctrl.en     = regs_q.ctrl.en | bus_wdata[BIT_EN];
            regs_d.ctrl.rst_en = bus_wdata[BIT_RSTEN];
            regs_d.ctrl.pulse  = bus_wdata[BIT_PULSE];
        end
        if (soft_rst) begin
            regs_d = REGS_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            IDX_LOAD:  bus_rdata[CNT_W-1:0] = regs_q.load;
            IDX_COUNT: bus_rdata[CNT_W-1:0] = count;
            IDX_CTRL: begin
                bus_rdata[BIT_EN]    = regs_q.ctrl.en;
                bus_rdata[BIT_RSTEN] = regs_q.ctrl.rst_en;
                bus_rdata[BIT_PULSE] = regs_q.ctrl.pulse;
            end
            default:   bus_rdata = '0;
        endcase
    end

    assign ctrl     = regs_q.ctrl;
    assign load_val = regs_q.load;
    assign load_new = bus_wdata[CNT_W-1:0];

endmodule

// File: rtl/guard_counter.sv
module guard_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             run,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] load_new,
    input  logic             load_wr,
    input  logic             clear_wr,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    localparam cnt_state_t CNT_RST = '{cnt: '1};

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = run && (cnt_q.cnt == '0);
        if (load_wr) begin
            cnt_d.cnt = load_new;
        end else if (clear_wr || expire) begin
            cnt_d.cnt = load_val;
        end else if (run) begin
            cnt_d.cnt = cnt_q.cnt - 1'b1;
        end
        if (soft_rst) begin
            cnt_d = CNT_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_RST;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q.cnt;

endmodule

// File: rtl/guard_irq.sv
module guard_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic expire,
    input  logic clear_wr,
    input  logic rst_en,
    input  logic pulse_mode,
    output logic irq,
    output logic rst_req
);

    typedef struct packed {
        logic status;
        logic pulse;
        logic rst_req;
    } irq_state_t;

    localparam irq_state_t IRQ_RST = '{status: 1'b0, pulse: 1'b0, rst_req: 1'b0};

    irq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (clear_wr) begin
            st_d.status = 1'b0;
        end else if (expire) begin
            if (!st_q.status) begin
                st_d.status = 1'b1;
                st_d.pulse  = 1'b1;
            end else if (rst_en) begin
                st_d.rst_req = 1'b1;
            end
        end
        if (soft_rst) begin
            st_d = IRQ_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= IRQ_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq     = pulse_mode ? st_q.pulse : st_q.status;
    assign rst_req = st_q.rst_req;

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] load_new;
    logic             load_wr;
    logic             clear_wr;
    logic [CNT_W-1:0] count;
    logic             expire;
    logic             run_en;
    logic             rst_en;
    logic             pulse_mode;

    assign run_en     = ctrl.en;
    assign rst_en     = ctrl.rst_en;
    assign pulse_mode = ctrl.pulse;

    guard_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count     (count),
        .ctrl      (ctrl),
        .load_val  (load_val),
        .load_new  (load_new),
        .load_wr   (load_wr),
        .clear_wr  (clear_wr),
        .bus_rdata (bus_rdata)
    );

    guard_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .run      (run_en),
        .load_val (load_val),
        .load_new (load_new),
        .load_wr  (load_wr),
        .clear_wr (clear_wr),
        .count    (count),
        .expire   (expire)
    );

    guard_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .expire     (expire),
        .clear_wr   (clear_wr),
        .rst_en     (rst_en),
        .pulse_mode (pulse_mode),
        .irq        (irq),
        .rst_req    (rst_req)
    );

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             irq,
    input logic             rst_req,
    input logic             run_en,
    input logic             rst_en,
    input logic             pulse_mode,
    input logic [CNT_W-1:0] count
);

    AST_ENABLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !soft_rst) |=> run_en); // R7

    AST_RSTREQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !soft_rst) |=> rst_req); // R4

    AST_RSTREQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(rst_en)); // R4

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !bus_wr && !soft_rst) |=> $stable(count)); // R2

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !bus_wr && !soft_rst && count != '0) |=> (count == $past(count) - 1'b1)); // R2

    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && !soft_rst) |=> !irq); // R5

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && irq) |=> !(pulse_mode && irq)); // R6

    always_comb begin
        if (rst_n && bus_addr == 2'd2) begin
            AST_CTRL_RSVD_ZERO: assert (bus_rdata[31:3] == 29'd0); // R9
        end
    end

endmodule

bind guard_timer guard_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .rst_req    (rst_req),
    .run_en     (run_en),
    .rst_en     (rst_en),
    .pulse_mode (pulse_mode),
    .count      (count)
);

// File: tb/test_guard_timer.sv
`timescale 1ns/1ps
module test_guard_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rst_req;

    int total = 0;
    int fails = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    guard_timer #(.CNT_W(32)) i_guard_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_now(input logic [1:0] a);
        bus_addr = a;
        #1;
        rd = bus_rdata;
    endtask

    task automatic pulse_soft;
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    initial begin
        #750000;
        total++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int first_irq, first_rst, high, clears;
        bit saw_rst;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_now(2'd2); chk("R1 ctrl", rd, 32'd0);
        read_now(2'd0); chk("R1 load", rd, 32'hFFFF_FFFF);
        read_now(2'd1); chk("R1 count", rd, 32'hFFFF_FFFF);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 rst_req", {31'd0, rst_req}, 32'd0);

        // sweep: load 0..7 x {rst_en, pulse}
        for (int l = 0; l < 8; l++) begin
            for (int m = 0; m < 4; m++) begin
                pulse_soft();
                read_now(2'd2); chk("R8 ctrl after soft reset", rd, 32'd0);
                chk("R8 rst_req after soft reset", {31'd0, rst_req}, 32'd0);
                bus_write(2'd0, l);
                read_now(2'd1); chk("R10 count after load", rd, l);
                repeat (3) @(negedge clk);
                read_now(2'd1); chk("R2 halted count", rd, l);
                bus_write(2'd2, (m << 1) | 1);
                first_irq = 0; first_rst = 0; high = 0;
                for (int c = 1; c <= 3 * l + 5; c++) begin
                    @(negedge clk);
                    if (irq) begin
                        high++;
                        if (first_irq == 0) first_irq = c;
                    end
                    if (rst_req && first_rst == 0) first_rst = c;
                end
                chk("R3 first time-out cycle", first_irq, l + 1);
                chk("R4 reset request cycle", first_rst, m[0] ? 2 * (l + 1) : 0);
                chk("R6 irq high cycles", high, m[1] ? 1 : 2 * l + 5);
            end
        end

        // R2 decrement and ignored count write
        pulse_soft();
        bus_write(2'd0, 32'd9);
        bus_write(2'd1, 32'd3);
        read_now(2'd1); chk("R2 count write ignored", rd, 32'd9);
        bus_write(2'd0, 32'd5);
        bus_write(2'd2, 32'd1);
        read_now(2'd1); chk("R2 running count start", rd, 32'd5);
        @(negedge clk);
        read_now(2'd1); chk("R2 running count step", rd, 32'd4);

        // R7 lock, R9 reserved bits
        pulse_soft();
        bus_write(2'd2, 32'd1);
        bus_write(2'd2, 32'd0);
        read_now(2'd2); chk("R7 enable stays set", rd, 32'd1);
        bus_write(2'd2, 32'd6);
        read_now(2'd2); chk("R7 other bits writable", rd, 32'd7);
        bus_write(2'd2, 32'd2);
        read_now(2'd2); chk("R7 pulse bit cleared", rd, 32'd3);
        bus_write(2'd2, 32'hFFFF_FFFF);
        read_now(2'd2); chk("R9 reserved read zero", rd, 32'd7);

        // R5 clearing in time prevents the reset request
        pulse_soft();
        bus_write(2'd0, 32'd4);
        bus_write(2'd2, 32'd3);
        clears = 0; saw_rst = 1'b0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (rst_req) saw_rst = 1'b1;
            if (irq) begin
                bus_write(2'd3, 32'hA5A5_0000);
                clears++;
                read_now(2'd1); chk("R5 clear reloads count", rd, 32'd4);
                chk("R5 clear drops irq", {31'd0, irq}, 32'd0);
            end
        end
        chk("R5 no reset when cleared", {31'd0, saw_rst}, 32'd0);
        chk("R5 clears performed", (clears >= 5) ? 32'd1 : 32'd0, 32'd1);

        // R8 hardware reset releases the lock
        bus_write(2'd2, 32'd1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_now(2'd2); chk("R8 hardware reset unlocks", rd, 32'd0);
        read_now(2'd0); chk("R8 hardware reset load", rd, 32'hFFFF_FFFF);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule